// File: doc/BRIEF.md
# Fault Escalation and Routing Unit

This block sits beside an exception controller and settles, in the same cycle a fault is reported, where that fault goes. A reported fault belongs to one of three configurable classes: memory-management, bus or usage. It is sent to its own class handler when that handler is enabled and can preempt the code now running. It is promoted to the fixed-priority HardFault when the handler is disabled, when the fault's configured level cannot beat the current execution priority, or when the class's own handler is already active. One case is exempt from promotion: a bus fault raised while stacking on entry to the bus-fault handler still enters that handler. A fault raised while HardFault, NMI or Reset is running cannot go anywhere, so the block raises a lockup indication.

Priorities are compared as signed numbers, and a smaller value is more urgent. Configurable levels run from 0 to 2^PRI_W-1. The running level `exec_pri` may also be -1 (HardFault), -2 (NMI) or -3 (Reset), and thread mode is 2^PRI_W. Routing outputs are combinational. A sticky HardFault-forced flag and six sticky usage-cause bits are updated on the clock edge that ends the fault-valid cycle. Software clears them with a write-one-to-clear strobe.

Top module: `fault_route_unit`

## Requirements
- R1: An enabled fault with class code 1 (memory), 2 (bus) or 3 (usage) is routed to its own handler when its configured level is numerically below `exec_pri` and no handler of the same class is active. The `handler` output then equals the class code and `preempt` is 1.
- R2: A fault whose class equals `act_cls`, the class of the fault handler now active, is routed to HardFault (`handler` = 4). This holds even when the configured level alone would allow preemption.
- R3: A fault whose configured level is equal to or numerically greater than `exec_pri` is routed to HardFault. This applies whether the running code is thread mode, a fault handler or any other exception.
- R4: A fault whose bit in `cls_en` is 0 is routed to HardFault. Bit 0 enables memory, bit 1 bus and bit 2 usage.
- R5: A bus fault with `stack_push` = 1 while `act_cls` = 2 (bus handler active) is routed to the bus handler (`handler` = 2, `preempt` = 1) and does not set the HardFault-forced flag.
- R6: A fault while `exec_pri` is negative drives `lockup` = 1, `handler` = 0 and `preempt` = 0, and does not set the forced flag.
- R7: Every fault routed to HardFault sets `hard_forced` on the following clock edge. The flag stays set until a clear write with `clr_data` bit 6 set.
- R8: A usage fault (class 3) with cause code c in 0..5 sets `cause_sts[c]` on the following edge, whether or not a handler is entered. The codes are 0 coprocessor access, 1 undefined instruction, 2 invalid instruction-set state, 3 invalid exception-return value, 4 unaligned access and 5 divide by zero. Codes 6 and 7, and faults of other classes, set no cause bit.
- R9: `clr_wr` with `clr_data[5:0]` clears the matching cause bits. When a bit is set and cleared in the same cycle, the set wins.
- R10: With `fault_vld` = 0, or with class code 0, `handler` = 0, `preempt` = 0, `lockup` = 0, and no status bit changes.
- R11: After reset, `cause_sts` and `hard_forced` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_vld | input | 1 | A fault is reported this cycle |
| fault_cls | input | 2 | Fault class: 1 memory, 2 bus, 3 usage, 0 none |
| usage_cause | input | 3 | Usage-fault cause code 0..5 |
| cls_pri | input | 3*PRI_W | Configured levels; memory in the low slice, then bus, then usage |
| cls_en | input | 3 | Per-class handler enable |
| exec_pri | input | PRI_W+2 | Signed current execution priority |
| act_cls | input | 2 | Class of the active fault handler, 0 if none |
| stack_push | input | 1 | Fault arose during the entry stack push |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 7 | Clear mask: bits 5:0 causes, bit 6 forced flag |
| handler | output | 3 | Chosen handler: 0 none, 1 memory, 2 bus, 3 usage, 4 HardFault |
| preempt | output | 1 | Chosen handler is entered now |
| lockup | output | 1 | Fault with no possible handler |
| hard_forced | output | 1 | Sticky: a fault was promoted to HardFault |
| cause_sts | output | 6 | Sticky usage-fault cause bits |

## Verification
The hardest case to reach is the stacking carve-out. It needs a bus fault, an active bus handler and the stacking flag together, with the configured level set so that, without the exemption, the fault would escalate by both the same-class rule and the priority rule. The stimulus builds exactly that case and then removes one condition at a time: the stacking flag, or the active class. Each variant must fall back to HardFault. The same-class rule is kept apart from the priority rule by making the running level less urgent than the fault's own level, so that only the active class can cause the promotion.

// File: rtl/fault_route_pkg.sv
package fault_route_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_MEM   = 2'd1,
    CLS_BUS   = 2'd2,
    CLS_USAGE = 2'd3
  } fclass_e;

  typedef enum logic [2:0] {
    HND_NONE  = 3'd0,
    HND_MEM   = 3'd1,
    HND_BUS   = 3'd2,
    HND_USAGE = 3'd3,
    HND_HARD  = 3'd4
  } handler_e;

  localparam int N_CLS   = 3;
  localparam int N_CAUSE = 6;
  localparam int CAUSE_W = 3;
endpackage

// File: rtl/fault_escalate.sv
module fault_escalate
  import fault_route_pkg::*;
#(
  parameter int PRI_W = 8
) (
  input  logic                    fault_vld,
  input  logic [1:0]              fault_cls,
  input  logic [N_CLS*PRI_W-1:0]  cls_pri,
  input  logic [N_CLS-1:0]        cls_en,
  input  logic signed [PRI_W+1:0] exec_pri,
  input  logic [1:0]              act_cls,
  input  logic                    stack_push,
  output logic [2:0]              handler,
  output logic                    preempt,
  output logic                    lockup,
  output logic                    promoted
);
  localparam int EPW = PRI_W + 2;

  logic [PRI_W-1:0]      pri_sel;
  logic                  en_sel;
  logic signed [EPW-1:0] cfg_ext;
  logic                  live;
  logic                  stuck;
  logic                  stack_keep;
  logic                  rule_hit;

  // pick the configured level and enable of the reporting class
  always_comb begin
    pri_sel = '0;
    en_sel  = 1'b0;
    for (int k = 0; k < N_CLS; k++) begin
      if (fault_cls == 2'(k + 1)) begin
        pri_sel = cls_pri[k*PRI_W +: PRI_W];
        en_sel  = cls_en[k];
      end
    end
  end

  assign cfg_ext    = signed'({2'b00, pri_sel});
  assign live       = fault_vld && (fault_cls != CLS_NONE);
  assign stuck      = exec_pri[EPW-1];
  assign stack_keep = (fault_cls == CLS_BUS) && (act_cls == CLS_BUS) && stack_push;
  assign rule_hit   = !en_sel || (act_cls == fault_cls) || (cfg_ext >= exec_pri);

  always_comb begin
    handler  = HND_NONE;
    preempt  = 1'b0;
    lockup   = 1'b0;
    promoted = 1'b0;
    if (live) begin
      if (stuck) begin
        lockup = 1'b1;
      end else if (stack_keep) begin
        handler = HND_BUS;
        preempt = 1'b1;
      end else if (rule_hit) begin
        handler  = HND_HARD;
        preempt  = 1'b1;
        promoted = 1'b1;
      end else begin
        handler = {1'b0, fault_cls};
        preempt = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
  import fault_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               usage_evt,
  input  logic [CAUSE_W-1:0] usage_cause,
  input  logic               forced_set,
  input  logic               clr_wr,
  input  logic [N_CAUSE:0]   clr_data,
  output logic [N_CAUSE-1:0] cause_sts,
  output logic               hard_forced
);
  logic [N_CAUSE-1:0] cause_set;
  logic [N_CAUSE-1:0] cause_d;
  logic               forced_d;
  logic               upd_en;

  for (genvar g = 0; g < N_CAUSE; g++) begin : g_dec
    assign cause_set[g] = usage_evt && (usage_cause == CAUSE_W'(g));
  end

  always_comb begin
    cause_d  = cause_sts;
    forced_d = hard_forced;
    if (clr_wr) begin
      cause_d  = cause_d & ~clr_data[N_CAUSE-1:0];
      forced_d = forced_d & ~clr_data[N_CAUSE];
    end
    cause_d  = cause_d | cause_set;
    forced_d = forced_d | forced_set;
  end

  assign upd_en = clr_wr || usage_evt || forced_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_sts   <= '0;
      hard_forced <= 1'b0;
    end else if (upd_en) begin
      cause_sts   <= cause_d;
      hard_forced <= forced_d;
    end
  end
endmodule

// File: rtl/fault_route_unit.sv
module fault_route_unit
  import fault_route_pkg::*;
#(
  parameter int PRI_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fault_vld,
  input  logic [1:0]              fault_cls,
  input  logic [2:0]              usage_cause,
  input  logic [3*PRI_W-1:0]      cls_pri,
  input  logic [2:0]              cls_en,
  input  logic signed [PRI_W+1:0] exec_pri,
  input  logic [1:0]              act_cls,
  input  logic                    stack_push,
  input  logic                    clr_wr,
  input  logic [6:0]              clr_data,
  output logic [2:0]              handler,
  output logic                    preempt,
  output logic                    lockup,
  output logic                    hard_forced,
  output logic [5:0]              cause_sts
);
  logic [1:0] rst_sync;
  logic       rst_q_n;
  logic       promoted;
  logic       usage_evt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  fault_escalate #(.PRI_W(PRI_W)) u_esc (
    .fault_vld  (fault_vld),
    .fault_cls  (fault_cls),
    .cls_pri    (cls_pri),
    .cls_en     (cls_en),
    .exec_pri   (exec_pri),
    .act_cls    (act_cls),
    .stack_push (stack_push),
    .handler    (handler),
    .preempt    (preempt),
    .lockup     (lockup),
    .promoted   (promoted)
  );

  assign usage_evt = fault_vld && (fault_cls == CLS_USAGE);

  fault_status_regs u_sts (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .usage_evt   (usage_evt),
    .usage_cause (usage_cause),
    .forced_set  (promoted),
    .clr_wr      (clr_wr),
    .clr_data    (clr_data),
    .cause_sts   (cause_sts),
    .hard_forced (hard_forced)
  );
endmodule

// File: rtl/fault_route_chk.sv
module fault_route_chk #(
  parameter int PRI_W = 8
) (
  input logic                    clk,
  input logic                    rst_q_n,
  input logic                    fault_vld,
  input logic [1:0]              fault_cls,
  input logic [2:0]              cls_en,
  input logic signed [PRI_W+1:0] exec_pri,
  input logic [1:0]              act_cls,
  input logic                    stack_push,
  input logic                    clr_wr,
  input logic [2:0]              handler,
  input logic                    preempt,
  input logic                    lockup,
  input logic                    hard_forced,
  input logic [5:0]              cause_sts
);
  logic live, neg, keep;
  assign live = fault_vld && (fault_cls != 2'd0);
  assign neg  = exec_pri[PRI_W+1];
  assign keep = (fault_cls == 2'd2) && (act_cls == 2'd2) && stack_push;

  assert_preempt_target_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    preempt |-> (handler != 3'd0));
  assert_same_class_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live && !neg && !keep && (act_cls == fault_cls)) |-> (handler == 3'd4));
  assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live && !neg && !keep && !cls_en[fault_cls - 2'd1]) |-> (handler == 3'd4));
  assert_stack_keep_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live && !neg && keep) |-> (handler == 3'd2 && preempt));
  assert_lockup_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live && neg) |-> (lockup && handler == 3'd0 && !preempt));
  assert_forced_set_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fault_vld && handler == 3'd4) |=> hard_forced);
  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clr_wr |=> ((cause_sts & $past(cause_sts)) == $past(cause_sts)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fault_vld |-> (handler == 3'd0 && !preempt && !lockup));
endmodule

bind fault_route_unit fault_route_chk #(.PRI_W(PRI_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .fault_vld   (fault_vld),
  .fault_cls   (fault_cls),
  .cls_en      (cls_en),
  .exec_pri    (exec_pri),
  .act_cls     (act_cls),
  .stack_push  (stack_push),
  .clr_wr      (clr_wr),
  .handler     (handler),
  .preempt     (preempt),
  .lockup      (lockup),
  .hard_forced (hard_forced),
  .cause_sts   (cause_sts)
);

// File: tb/tb_fault_route_unit.sv
`timescale 1ns/1ps
module tb_fault_route_unit;
  localparam int PRI_W = 8;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    fault_vld;
  logic [1:0]              fault_cls;
  logic [2:0]              usage_cause;
  logic [3*PRI_W-1:0]      cls_pri;
  logic [2:0]              cls_en;
  logic signed [PRI_W+1:0] exec_pri;
  logic [1:0]              act_cls;
  logic                    stack_push;
  logic                    clr_wr;
  logic [6:0]              clr_data;
  logic [2:0]              handler;
  logic                    preempt;
  logic                    lockup;
  logic                    hard_forced;
  logic [5:0]              cause_sts;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [2:0] h_s;
  logic       p_s, l_s;

  always #2.5 clk = ~clk;

  fault_route_unit #(.PRI_W(PRI_W)) dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] cls, input logic [2:0] cause);
    @(negedge clk);
    fault_vld   = 1'b1;
    fault_cls   = cls;
    usage_cause = cause;
    #1;
    h_s = handler; p_s = preempt; l_s = lockup;
    @(negedge clk);
    fault_vld = 1'b0;
  endtask

  task automatic clear(input logic [6:0] m);
    @(negedge clk);
    clr_wr = 1'b1; clr_data = m;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic setup(input int ex, input logic [1:0] act, input logic sp);
    exec_pri = (PRI_W+2)'(ex); act_cls = act; stack_push = sp;
    cls_en = 3'b111;
  endtask

  task automatic t_reset();
    chk(cause_sts, 0, "R11 cause after reset");
    chk(hard_forced, 0, "R11 forced after reset");
    chk(handler, 0, "R10 idle handler");
    chk(lockup, 0, "R10 idle lockup");
  endtask

  task automatic t_route();
    setup(256, 2'd0, 1'b0);
    for (int c = 1; c <= 3; c++) begin
      fire(2'(c), 3'd7);
      chk(h_s, c, "R1 own handler");
      chk(p_s, 1, "R1 preempt");
    end
    chk(hard_forced, 0, "R1 no forced flag");
    setup(65, 2'd0, 1'b0);
    fire(2'd2, 3'd0);
    chk(h_s, 2, "R3 boundary just above passes");
  endtask

  task automatic t_same();
    setup(256, 2'd3, 1'b0);
    fire(2'd3, 3'd7);
    chk(h_s, 4, "R2 same class to hard");
    chk(hard_forced, 1, "R7 forced set");
    clear(7'h40);
    chk(hard_forced, 0, "R7 forced cleared");
    setup(256, 2'd1, 1'b0);
    fire(2'd3, 3'd7);
    chk(h_s, 3, "R2 other class active routes own");
  endtask

  task automatic t_pri();
    setup(64, 2'd0, 1'b0);
    fire(2'd2, 3'd7);
    chk(h_s, 4, "R3 equal level to hard");
    setup(48, 2'd0, 1'b0);
    fire(2'd2, 3'd7);
    chk(h_s, 4, "R3 lower urgency to hard");
    setup(32, 2'd1, 1'b0);
    fire(2'd2, 3'd7);
    chk(h_s, 4, "R3 inside fault handler to hard");
    clear(7'h40);
  endtask

  task automatic t_disabled();
    setup(256, 2'd0, 1'b0);
    cls_en = 3'b011;
    fire(2'd3, 3'd7);
    chk(h_s, 4, "R4 disabled usage to hard");
    cls_en = 3'b110;
    fire(2'd1, 3'd7);
    chk(h_s, 4, "R4 disabled memory to hard");
    cls_en = 3'b111;
    clear(7'h40);
  endtask

  task automatic t_stack();
    setup(64, 2'd2, 1'b1);
    fire(2'd2, 3'd7);
    chk(h_s, 2, "R5 stacking bus fault kept");
    chk(p_s, 1, "R5 preempt");
    chk(hard_forced, 0, "R5 no forced flag");
    setup(64, 2'd2, 1'b0);
    fire(2'd2, 3'd7);
    chk(h_s, 4, "R5 no stacking flag escalates");
    setup(32, 2'd1, 1'b1);
    fire(2'd2, 3'd7);
    chk(h_s, 4, "R5 other active class escalates");
    clear(7'h40);
  endtask

  task automatic t_lockup();
    setup(-1, 2'd0, 1'b0);
    fire(2'd1, 3'd7);
    chk(l_s, 1, "R6 lockup under hardfault");
    chk(h_s, 0, "R6 no handler");
    chk(p_s, 0, "R6 no preempt");
    setup(-2, 2'd0, 1'b0);
    fire(2'd3, 3'd5);
    chk(l_s, 1, "R6 lockup under nmi");
    chk(hard_forced, 0, "R6 no forced flag");
    chk(cause_sts, 32, "R8 cause recorded in lockup");
    clear(7'h7f);
  endtask

  task automatic t_causes();
    setup(256, 2'd0, 1'b0);
    for (int c = 0; c < 8; c++) begin
      fire(2'd3, 3'(c));
      chk(cause_sts, (c < 6) ? (1 << c) : 0, "R8 cause bit");
      clear(7'h3f);
    end
    fire(2'd2, 3'd1);
    chk(cause_sts, 0, "R8 bus fault sets no cause");
  endtask

  task automatic t_w1c();
    setup(256, 2'd0, 1'b0);
    fire(2'd3, 3'd0);
    fire(2'd3, 3'd4);
    chk(cause_sts, 17, "R9 two causes held");
    clear(7'h01);
    chk(cause_sts, 16, "R9 partial clear");
    @(negedge clk);
    fault_vld = 1'b1; fault_cls = 2'd3; usage_cause = 3'd4;
    clr_wr = 1'b1; clr_data = 7'h10;
    @(negedge clk);
    fault_vld = 1'b0; clr_wr = 1'b0; clr_data = '0;
    chk(cause_sts, 16, "R9 set wins over clear");
    clear(7'h3f);
  endtask

  task automatic t_idle();
    setup(256, 2'd0, 1'b0);
    @(negedge clk);
    fault_vld = 1'b0; fault_cls = 2'd3; usage_cause = 3'd2;
    #1;
    chk(handler, 0, "R10 no valid no handler");
    chk(preempt, 0, "R10 no valid no preempt");
    @(negedge clk);
    chk(cause_sts, 0, "R10 status unchanged");
    fire(2'd0, 3'd2);
    chk(h_s, 0, "R10 class zero ignored");
    chk(hard_forced, 0, "R10 class zero no flag");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fault_vld = 1'b0; fault_cls = '0; usage_cause = '0;
    cls_pri = {8'h60, 8'h40, 8'h20}; cls_en = 3'b111;
    exec_pri = 10'sd256; act_cls = '0; stack_push = 1'b0;
    clr_wr = 1'b0; clr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_route();
    t_same();
    t_pri();
    t_disabled();
    t_stack();
    t_lockup();
    t_causes();
    t_w1c();
    t_idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule